// File: doc/BRIEF.md
# Raster-Timed Display Program Sequencer

This block is a small coprocessor that steps through a byte-coded program held in local memory, in time with the scan position of a video beam. The beam position arrives as a raster line number and a cycle number within the line. Each instruction either waits for a beam position, waits for a relative distance, changes program flow, works on one of two loop counters, or writes a byte into a numbered register of the video chip. Register writes leave the block as a single-cycle strobe with a register number and a data byte.

A frame-start pulse aborts whatever the program is doing and restarts it from a start address supplied at the block's input. A program can therefore end in an endless loop or an endless wait without harm. Memory is read through one synchronous port that returns a pair of bytes one cycle after the address. The address is the next program counter, so a two-byte instruction still issues in a single cycle, and a taken branch costs no bubble.

Top module: `raster_list_seq`

## Requirements
- R1: While reset is held, `wr_en` stays low. After reset nothing executes until the first `frame_start` pulse.
- R2: A `frame_start` pulse wins over any instruction or stall in progress. In that cycle `mem_addr` equals `list_base`, no strobe follows in the next cycle, and execution starts at `list_base` in the cycle after the pulse. Loop counter values survive the restart.
- R3: A first byte with bit 7 set is WAIT. The line is {byte0[6:0], byte1[7:6]} and the cycle is byte1[5:0]. The next instruction runs in the cycle after the first cycle in which (line > target) or (line == target and cycle >= target cycle). A target that has already passed therefore costs one cycle. Cycle 63 is reached only at the start of the following line. The byte pair 0xFF 0xFF never completes.
- R4: A first byte of the form 01RRRRRR is MOV, and the second byte is the data. `wr_en` is high for one cycle, in the cycle after the MOV executes, with `wr_reg` = RRRRRR and `wr_data` = the data byte.
- R5: 0x20 n waits until the start (cycle 0) of the line n lines below the line in which it executed. The next instruction runs one cycle after that. With n = 0 it takes one cycle.
- R6: 0x21 n makes the next instruction run n cycles later than it otherwise would. With n = 0 it takes one cycle.
- R7: 0x22 d jumps to (address after the two-byte instruction) + d, with d a signed byte. d = 0 falls through and d = -2 loops on itself.
- R8: 0x23 v and 0x24 v load counter A or B with v. The one-byte codes 0x30 (A) and 0x31 (B) skip the next two bytes when their counter is zero. Otherwise they decrement it and continue.
- R9: Instructions that do not wait execute one per cycle. 0x3F and every unassigned code from 0x00 to 0x3F are one-byte no-ops. `mem_addr` is the address read at the next clock edge, and `mem_rdata[7:0]` holds the byte at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Pulse marking the first cycle of a frame |
| beam_line | input | 9 | Current raster line |
| beam_cyc | input | 6 | Current cycle within the line |
| list_base | input | 16 | Program start address, taken at frame start |
| mem_addr | output | 16 | Address of the byte pair read at the next edge |
| mem_rdata | input | 16 | Byte pair from memory, lower address in bits 7:0 |
| wr_en | output | 1 | Register-write strobe |
| wr_reg | output | 6 | Register number of the write |
| wr_data | output | 8 | Data byte of the write |

## Verification
The bound checker watches, on every cycle, the relations visible at the memory port. These are the reload of the start address on frame start, the silence after an abort or while idle, the fields and one-cycle lag of each MOV strobe, the two-byte and one-byte strides, and the held address during an unsatisfied WAIT. The exact cycle at which a write appears after relative delays, branches, counter skips and cycle-63 targets only shows up in the bench. The bench runs directed and random programs in alternating memory regions and compares every write's register, data and beam timestamp against an instruction-level model. Restart out of endless stalls and self-loops is shown by the writes of the following frame.

// File: rtl/rls_pkg.sv
package rls_pkg;
    localparam int BYTE_W  = 8;
    localparam int WLINE_W = 9;
    localparam int WCYC_W  = 6;
    localparam int MREG_W  = 6;
    localparam int NUM_CNT = 2;

    localparam logic [BYTE_W-1:0] OPC_DLYV = 8'h20;
    localparam logic [BYTE_W-1:0] OPC_DLYH = 8'h21;
    localparam logic [BYTE_W-1:0] OPC_BRA  = 8'h22;
    localparam logic [BYTE_W-1:0] OPC_SETA = 8'h23;
    localparam logic [BYTE_W-1:0] OPC_SETB = 8'h24;
    localparam logic [BYTE_W-1:0] OPC_DECA = 8'h30;
    localparam logic [BYTE_W-1:0] OPC_DECB = 8'h31;

    typedef enum logic [3:0] {
        K_WAIT, K_MOV, K_DLYV, K_DLYH, K_BRA,
        K_SETA, K_SETB, K_DECA, K_DECB, K_NOP
    } kind_e;
endpackage

// File: rtl/rls_decode.sv
module rls_decode
    import rls_pkg::*;
(
    input  logic [BYTE_W-1:0] op_byte,
    output kind_e             kind
);
    always_comb begin
        if (op_byte[7]) begin
            kind = K_WAIT;
        end else if (op_byte[6]) begin
            kind = K_MOV;
        end else begin
            case (op_byte)
                OPC_DLYV: kind = K_DLYV;
                OPC_DLYH: kind = K_DLYH;
                OPC_BRA:  kind = K_BRA;
                OPC_SETA: kind = K_SETA;
                OPC_SETB: kind = K_SETB;
                OPC_DECA: kind = K_DECA;
                OPC_DECB: kind = K_DECB;
                default:  kind = K_NOP;
            endcase
        end
    end
endmodule

// File: rtl/rls_beam_cmp.sv
module rls_beam_cmp #(
    parameter int LW = 9,
    parameter int CW = 6
) (
    input  logic [LW-1:0] cur_line,
    input  logic [CW-1:0] cur_cyc,
    input  logic [LW-1:0] tgt_line,
    input  logic [CW-1:0] tgt_cyc,
    output logic          reached
);
    logic line_past;
    logic line_same;

    assign line_past = cur_line > tgt_line;
    assign line_same = cur_line == tgt_line;
    assign reached   = line_past || (line_same && (cur_cyc >= tgt_cyc));
endmodule

// File: rtl/rls_counters.sv
module rls_counters #(
    parameter int NUM = 2,
    parameter int W   = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] load,
    input  logic [NUM-1:0] dec,
    input  logic [W-1:0]   load_val,
    output logic [NUM-1:0] is_zero
);
    logic [W-1:0] cnt_d [NUM];
    logic [W-1:0] cnt_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        always_comb begin
            cnt_d[g] = cnt_q[g];
            if (load[g]) begin
                cnt_d[g] = load_val;
            end else if (dec[g]) begin
                cnt_d[g] = cnt_q[g] - W'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else begin
                cnt_q[g] <= cnt_d[g];
            end
        end

        assign is_zero[g] = (cnt_q[g] == '0);
    end
endmodule

// File: rtl/raster_list_seq.sv
module raster_list_seq
    import rls_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 9,
    parameter int CYC_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic [LINE_W-1:0]   beam_line,
    input  logic [CYC_W-1:0]    beam_cyc,
    input  logic [ADDR_W-1:0]   list_base,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [2*BYTE_W-1:0] mem_rdata,
    output logic                wr_en,
    output logic [MREG_W-1:0]   wr_reg,
    output logic [BYTE_W-1:0]   wr_data
);
    localparam int TLINE_W = LINE_W + 1;
    localparam int SEXT_W  = ADDR_W - BYTE_W;

    typedef struct packed {
        logic                run;
        logic [ADDR_W-1:0]   pc;
        logic                busy;
        logic [TLINE_W-1:0]  tgt_line;
        logic [BYTE_W-1:0]   hcnt;
        logic                wr_en;
        logic [MREG_W-1:0]   wr_reg;
        logic [BYTE_W-1:0]   wr_data;
    } state_t;

    state_t d;
    state_t q;

    logic [BYTE_W-1:0]  byte0;
    logic [BYTE_W-1:0]  byte1;
    kind_e              kind;
    logic [LINE_W-1:0]  wait_line;
    logic [CYC_W-1:0]   wait_cyc;
    logic               wait_hit;
    logic               vdly_hit;
    logic [ADDR_W-1:0]  pc_p1;
    logic [ADDR_W-1:0]  pc_p2;
    logic [ADDR_W-1:0]  pc_p3;
    logic [ADDR_W-1:0]  bra_dst;
    logic [NUM_CNT-1:0] cnt_ld;
    logic [NUM_CNT-1:0] cnt_dec;
    logic [NUM_CNT-1:0] cnt_zero;
    logic               run_q;
    logic [ADDR_W-1:0]  pc_q;

    assign byte0     = mem_rdata[BYTE_W-1:0];
    assign byte1     = mem_rdata[2*BYTE_W-1:BYTE_W];
    assign wait_line = LINE_W'({byte0[6:0], byte1[7:6]});
    assign wait_cyc  = CYC_W'(byte1[5:0]);
    assign pc_p1     = q.pc + ADDR_W'(1);
    assign pc_p2     = q.pc + ADDR_W'(2);
    assign pc_p3     = q.pc + ADDR_W'(3);
    assign bra_dst   = pc_p2 + {{SEXT_W{byte1[7]}}, byte1};

    rls_decode u_dec (
        .op_byte (byte0),
        .kind    (kind)
    );

    rls_beam_cmp #(.LW(LINE_W), .CW(CYC_W)) u_wait_cmp (
        .cur_line (beam_line),
        .cur_cyc  (beam_cyc),
        .tgt_line (wait_line),
        .tgt_cyc  (wait_cyc),
        .reached  (wait_hit)
    );

    rls_beam_cmp #(.LW(TLINE_W), .CW(1)) u_vdly_cmp (
        .cur_line ({1'b0, beam_line}),
        .cur_cyc  (1'b0),
        .tgt_line (q.tgt_line),
        .tgt_cyc  (1'b0),
        .reached  (vdly_hit)
    );

    rls_counters #(.NUM(NUM_CNT), .W(BYTE_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_ld),
        .dec      (cnt_dec),
        .load_val (byte1),
        .is_zero  (cnt_zero)
    );

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        cnt_ld  = '0;
        cnt_dec = '0;
        if (frame_start) begin
            d.run  = 1'b1;
            d.pc   = list_base;
            d.busy = 1'b0;
        end else if (q.run) begin
            case (kind)
                K_WAIT: begin
                    if (wait_hit) begin
                        d.pc = pc_p2;
                    end
                end
                K_MOV: begin
                    d.wr_en   = 1'b1;
                    d.wr_reg  = byte0[MREG_W-1:0];
                    d.wr_data = byte1;
                    d.pc      = pc_p2;
                end
                K_DLYV: begin
                    if (!q.busy) begin
                        if (byte1 == '0) begin
                            d.pc = pc_p2;
                        end else begin
                            d.busy     = 1'b1;
                            d.tgt_line = {1'b0, beam_line} + TLINE_W'(byte1);
                        end
                    end else if (vdly_hit) begin
                        d.busy = 1'b0;
                        d.pc   = pc_p2;
                    end
                end
                K_DLYH: begin
                    if (!q.busy) begin
                        if (byte1 == '0) begin
                            d.pc = pc_p2;
                        end else begin
                            d.busy = 1'b1;
                            d.hcnt = byte1;
                        end
                    end else if (q.hcnt == BYTE_W'(1)) begin
                        d.busy = 1'b0;
                        d.pc   = pc_p2;
                    end else begin
                        d.hcnt = q.hcnt - BYTE_W'(1);
                    end
                end
                K_BRA: begin
                    d.pc = bra_dst;
                end
                K_SETA: begin
                    cnt_ld[0] = 1'b1;
                    d.pc      = pc_p2;
                end
                K_SETB: begin
                    cnt_ld[1] = 1'b1;
                    d.pc      = pc_p2;
                end
                K_DECA: begin
                    if (cnt_zero[0]) begin
                        d.pc = pc_p3;
                    end else begin
                        cnt_dec[0] = 1'b1;
                        d.pc       = pc_p1;
                    end
                end
                K_DECB: begin
                    if (cnt_zero[1]) begin
                        d.pc = pc_p3;
                    end else begin
                        cnt_dec[1] = 1'b1;
                        d.pc       = pc_p1;
                    end
                end
                default: begin
                    d.pc = pc_p1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr = d.pc;
    assign wr_en    = q.wr_en;
    assign wr_reg   = q.wr_reg;
    assign wr_data  = q.wr_data;
    assign run_q    = q.run;
    assign pc_q     = q.pc;
endmodule

// File: rtl/rls_checker.sv
module rls_checker #(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 9,
    parameter int CYC_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic [LINE_W-1:0] beam_line,
    input logic [CYC_W-1:0]  beam_cyc,
    input logic [ADDR_W-1:0] list_base,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_rdata,
    input logic              wr_en,
    input logic [5:0]        wr_reg,
    input logic [7:0]        wr_data,
    input logic              run,
    input logic [ADDR_W-1:0] pc
);
    logic              live;
    logic              is_mov;
    logic              is_wait;
    logic [LINE_W-1:0] w_line;
    logic [CYC_W-1:0]  w_cyc;
    logic              w_done;

    assign live    = run && !frame_start;
    assign is_mov  = mem_rdata[7:6] == 2'b01;
    assign is_wait = mem_rdata[7];
    assign w_line  = LINE_W'({mem_rdata[6:0], mem_rdata[15:14]});
    assign w_cyc   = CYC_W'(mem_rdata[13:8]);
    assign w_done  = (beam_line > w_line) || ((beam_line == w_line) && (beam_cyc >= w_cyc));

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !frame_start) |=> !wr_en); // R1

    AST_FRAME_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (mem_addr == list_base)); // R2

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !wr_en); // R2

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (live && is_wait && !w_done) |-> (mem_addr == pc)); // R3

    AST_MOV_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && is_mov) |=> (wr_en && (wr_reg == $past(mem_rdata[5:0])) && (wr_data == $past(mem_rdata[15:8])))); // R4

    AST_MOV_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (live && is_mov) |-> (mem_addr == pc + ADDR_W'(2))); // R9

    AST_NOP_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (live && (mem_rdata[7:0] == 8'h3F)) |-> (mem_addr == pc + ADDR_W'(1))); // R9
endmodule

bind raster_list_seq rls_checker #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .CYC_W  (CYC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .beam_line   (beam_line),
    .beam_cyc    (beam_cyc),
    .list_base   (list_base),
    .mem_addr    (mem_addr),
    .mem_rdata   (mem_rdata),
    .wr_en       (wr_en),
    .wr_reg      (wr_reg),
    .wr_data     (wr_data),
    .run         (run_q),
    .pc          (pc_q)
);

// File: tb/sim_raster_list_seq.sv
`timescale 1ns/1ps
module sim_raster_list_seq;
    localparam int CPL   = 63;
    localparam int LINES = 64;
    localparam int FRAME = CPL * LINES;
    localparam int NFR   = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  line_q;
    logic [5:0]  cyc_q;
    logic        frame_start;
    logic [15:0] list_base = '0;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        wr_en;
    logic [5:0]  wr_reg;
    logic [7:0]  wr_data;
    logic [7:0]  mem [512];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int wp;
    int a_m, b_m;
    int exp_n, got_n;
    int exp_reg [64], exp_dat [64], exp_t [64];
    int got_reg [64], got_dat [64], got_t [64];

    always #2.5 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            cyc_q  <= '0;
        end else if (cyc_q == 6'(CPL - 1)) begin
            cyc_q  <= '0;
            line_q <= (line_q == 9'(LINES - 1)) ? 9'd0 : line_q + 9'd1;
        end else begin
            cyc_q <= cyc_q + 6'd1;
        end
    end

    assign frame_start = rst_n && (line_q == 9'd0) && (cyc_q == 6'd0);

    always @(posedge clk) begin
        mem_rdata <= {mem[9'(mem_addr + 16'd1)], mem[9'(mem_addr)]};
    end

    raster_list_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .beam_line   (line_q),
        .beam_cyc    (cyc_q),
        .list_base   (list_base),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .wr_en       (wr_en),
        .wr_reg      (wr_reg),
        .wr_data     (wr_data)
    );

    always begin
        @(posedge clk);
        #1;
        if (rst_n && wr_en) begin
            if (got_n < 64) begin
                got_reg[got_n] = int'(wr_reg);
                got_dat[got_n] = int'(wr_data);
                got_t[got_n]   = int'(line_q) * CPL + int'(cyc_q);
            end
            got_n++;
        end
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic emit(input int b);
        mem[wp & 511] = 8'(b);
        wp++;
    endtask

    task automatic put_wait(input int ln, input int cy);
        emit(8'h80 | ((ln >> 2) & 8'h7F));
        emit(((ln & 3) << 6) | (cy & 63));
    endtask

    task automatic put_mov(input int rg, input int dt);
        emit(8'h40 | (rg & 63));
        emit(dt);
    endtask

    task automatic add_exp(input int rg, input int dt, input int t);
        if (exp_n < 64) begin
            exp_reg[exp_n] = rg;
            exp_dat[exp_n] = dt;
            exp_t[exp_n]   = t;
        end
        exp_n++;
    endtask

    // Instruction-level model of one frame from the requirements (R3..R9)
    task automatic iss(input int base);
        int pc, t, steps, wl, wc, r, tl;
        logic [7:0] b0, b1;
        pc = base; t = 1; steps = 0; exp_n = 0;
        while (t < FRAME && steps < 6000) begin
            steps++;
            b0 = mem[pc & 511];
            b1 = mem[(pc + 1) & 511];
            if (b0[7]) begin
                wl = {b0[6:0], b1[7:6]};
                wc = int'(b1[5:0]);
                r  = (wc <= CPL - 1) ? wl * CPL + wc : (wl + 1) * CPL;
                if (r >= FRAME) break;
                t  = ((r > t) ? r : t) + 1;
                pc += 2;
            end else if (b0[6]) begin
                add_exp(int'(b0[5:0]), int'(b1), t + 1);
                t++; pc += 2;
            end else begin
                case (b0)
                    8'h20: begin
                        if (b1 == 0) t++;
                        else begin
                            tl = t / CPL + int'(b1);
                            if (tl * CPL >= FRAME) break;
                            t = tl * CPL + 1;
                        end
                        pc += 2;
                    end
                    8'h21: begin t += int'(b1) + 1; pc += 2; end
                    8'h22: begin pc = pc + 2 + int'($signed(b1)); t++; end
                    8'h23: begin a_m = int'(b1); pc += 2; t++; end
                    8'h24: begin b_m = int'(b1); pc += 2; t++; end
                    8'h30: begin
                        if (a_m == 0) pc += 3; else begin a_m--; pc++; end
                        t++;
                    end
                    8'h31: begin
                        if (b_m == 0) pc += 3; else begin b_m--; pc++; end
                        t++;
                    end
                    default: begin pc++; t++; end
                endcase
            end
        end
    endtask

    task automatic gen_program(input int f, input int base);
        int n, k;
        for (int i = 0; i < 256; i++) mem[(base + i) & 511] = 8'hFF;
        wp = base;
        case (f)
            0: begin // R2: endless relative stall aborted by the next frame
                put_wait(2, 5); put_mov(6'h20, 8'h11); emit(8'h20); emit(200);
            end
            1: begin // R8: counted loop with backward branch
                emit(8'h23); emit(1); put_mov(6'h21, 8'h05); emit(8'h30); emit(8'h22); emit(8'hFB);
            end
            2: begin // R5 R6 R7: zero operands, past wait, self loop
                put_wait(3, 62); put_mov(6'h3F, 8'hAB); emit(8'h22); emit(0);
                emit(8'h20); emit(0); emit(8'h21); emit(0); emit(8'h21); emit(3);
                put_mov(6'h01, 8'h02); put_wait(0, 0); put_mov(6'h02, 8'h03);
                emit(8'h20); emit(1); put_mov(6'h03, 8'h04); emit(8'h22); emit(8'hFE);
            end
            3: begin // R3 cycle-63 target, R8 skip on zero counter B
                put_wait(4, 63); put_mov(6'h10, 8'h55); emit(8'h24); emit(0);
                emit(8'h31); put_mov(6'h11, 8'h66); put_mov(6'h12, 8'h77);
            end
            default: begin // R9: random mixture
                put_wait($urandom_range(20, 1), $urandom_range(62, 0));
                n = $urandom_range(12, 4);
                for (int i = 0; i < n; i++) begin
                    case ($urandom_range(7, 0))
                        0: put_mov($urandom_range(63, 0), $urandom_range(255, 0));
                        1: begin
                            k = $urandom_range(5, 0);
                            emit(k == 0 ? 8'h3F : k == 1 ? 8'h00 : k == 2 ? 8'h1F :
                                 k == 3 ? 8'h25 : k == 4 ? 8'h2F : 8'h3E);
                        end
                        2: begin emit(8'h21); emit($urandom_range(5, 0)); end
                        3: begin emit(8'h20); emit($urandom_range(2, 0)); end
                        4: begin emit($urandom_range(1, 0) ? 8'h23 : 8'h24); emit($urandom_range(2, 0)); end
                        5: begin emit(8'h30 | $urandom_range(1, 0)); put_mov($urandom_range(63, 0), $urandom_range(255, 0)); end
                        6: begin emit(8'h22); emit(2); put_mov($urandom_range(63, 0), $urandom_range(255, 0)); end
                        default: put_wait(0, 0);
                    endcase
                end
            end
        endcase
        emit(8'hFF); emit(8'hFF);
        list_base = 16'(base);
        iss(base);
    endtask

    function automatic string tag_of(input int f);
        case (f)
            0: return "R2";
            1: return "R8";
            2: return "R5 R6 R7";
            3: return "R3 R8";
            default: return "R9";
        endcase
    endfunction

    task automatic compare_frame(input int f);
        string tg;
        int m;
        tg = tag_of(f);
        check(got_n == exp_n, tg, "write count", got_n, exp_n);
        m = (got_n < exp_n) ? got_n : exp_n;
        if (m > 64) m = 64;
        for (int i = 0; i < m; i++) begin
            check(got_reg[i] == exp_reg[i], "R4", "register number", got_reg[i], exp_reg[i]);
            check(got_dat[i] == exp_dat[i], "R4", "data byte", got_dat[i], exp_dat[i]);
            check(got_t[i] == exp_t[i], tg, "strobe beam time", got_t[i], exp_t[i]);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        got_n = 0; a_m = 0; b_m = 0;
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        gen_program(0, 0);
        repeat (4) begin
            @(negedge clk);
            check(wr_en == 1'b0, "R1", "strobe during reset", int'(wr_en), 0);
        end
        rst_n = 1'b1;
        for (int f = 0; f < NFR; f++) begin
            do @(negedge clk); while (!(line_q == 9'(LINES - 1) && cyc_q == 6'(CPL - 1)));
            compare_frame(f);
            got_n = 0;
            gen_program(f + 1, ((f + 1) % 2) * 256);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule